// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management register set of an Ethernet PHY. Software reaches it through two words on a simple 32-bit register bus: a command word and a data word. Writing the command word names a PHY address, a PHY register number and a direction. When the PHY address matches the configured address, the transfer is carried out at once. A read places the PHY register value in the data word. A write takes the value that the data word already holds.

The responder models a small PHY register set. It has a control register that resets itself, a status register whose link bit follows an external input, an advertisement register that software can read and write, two fixed identifier words and a fixed link-partner word. Register numbers outside that set read as zero. No serial MDIO timing or negotiation is modelled: every transfer finishes in the clock edge that accepts the command.

Bus map: the command word sits at byte offset 0x00 and the data word at 0x04. Any other offset reads as zero and ignores writes.

Top module: `mgmt_reg_responder`

## Requirements
- R1: After reset the command word and the data word read 0. PHY register 0 reads 0x3100 and PHY register 4 reads 0x0000.
- R2: The command word uses these fields: bits 15:12 hold the PHY address, bits 7:4 the register number, bit 1 the direction (1 = write, 0 = read) and bit 0 the busy flag. A command write stores all 32 bits except bit 0, which always reads back as 0.
- R3: A matching read command loads the data word at the same edge that accepts the command. A bus read in the very next cycle returns the result.
- R4: A command whose PHY address field differs from `cfg_phy_addr_i` changes neither the data word nor any PHY register.
- R5: A write to PHY register 0 with bit 15 clear stores the low 16 data bits with bits 15 and 9 forced to 0.
- R6: A write to PHY register 0 with bit 15 set restores register 0 to 0x3100 and register 4 to 0x0000.
- R7: PHY register 1 reads 0xFE28, with bit 2 equal to `link_up_i`. A control-register reset does not alter bit 2.
- R8: PHY registers 2 and 3 read 0x0044 and 0x1400. Writes to them are ignored.
- R9: PHY register 4 stores the low 16 bits of the data word on a write and returns them on a read.
- R10: PHY register 5 reads 0x0DE0. Writes to it are ignored.
- R11: A read of any PHY register number from 6 to 15 loads 0 into the data word. Every PHY read clears data bits 31:16.
- R12: A bus write to the data word stores all 32 bits, and the data word reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_phy_addr_i | input | 4 | PHY address this responder answers to |
| link_up_i | input | 1 | Link state shown in status bit 2 |
| bus_en_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Bus access is a write |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational on bus_addr_i |

## Verification
Each result appears one cycle after its stimulus. The command word, the data word and the PHY registers all change at the edge that accepts the bus write. Bus read data is a combinational view of those registers. The bench drives each access on a falling edge and removes it at the next falling edge. It samples read data shortly after a falling edge, so every check sees the state left by the preceding rising edge. The R3 check reads the data word in the first cycle after the command write, which shows that the result is not delayed further.

// File: rtl/mgmt_resp_pkg.sv
package mgmt_resp_pkg;
  localparam int unsigned PHY_W    = 16;
  localparam int unsigned PA_W     = 4;
  localparam int unsigned RN_W     = 4;
  // command field positions (software decodes these)
  localparam int unsigned CMD_PA_LSB = 12;
  localparam int unsigned CMD_RN_LSB = 4;
  localparam int unsigned CMD_DIR_BIT = 1;
  localparam int unsigned CMD_BUSY_BIT = 0;

  localparam logic [PHY_W-1:0] CTRL_DEFAULT = 16'h3100;
  localparam logic [PHY_W-1:0] CTRL_KEEP    = 16'h7DFF;
  localparam int unsigned      CTRL_RST_BIT = 15;
  localparam logic [PHY_W-1:0] STAT_BASE    = 16'hFE28;
  localparam int unsigned      STAT_LINK_BIT = 2;
  localparam logic [PHY_W-1:0] IDENT_HI     = 16'h0044;
  localparam logic [PHY_W-1:0] IDENT_LO     = 16'h1400;
  localparam logic [PHY_W-1:0] PARTNER_ABIL = 16'h0DE0;

  typedef enum logic [RN_W-1:0] {
    PR_CTRL  = 4'd0,
    PR_STAT  = 4'd1,
    PR_IDHI  = 4'd2,
    PR_IDLO  = 4'd3,
    PR_ADV   = 4'd4,
    PR_PART  = 4'd5
  } phy_reg_e;
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
  import mgmt_resp_pkg::*;
(
  input  logic            cmd_stb_i,
  input  logic [PA_W-1:0] cmd_pa_i,
  input  logic [RN_W-1:0] cmd_rn_i,
  input  logic            cmd_dir_i,
  input  logic [PA_W-1:0] cfg_pa_i,
  output logic            exec_rd_o,
  output logic            exec_wr_o,
  output logic [RN_W-1:0] reg_idx_o
);
  logic hit;
  assign hit       = cmd_stb_i && (cmd_pa_i == cfg_pa_i);
  assign exec_rd_o = hit && !cmd_dir_i;
  assign exec_wr_o = hit &&  cmd_dir_i;
  assign reg_idx_o = cmd_rn_i;
endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
  import mgmt_resp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [RN_W-1:0]  reg_i,
  input  logic [PHY_W-1:0] wdata_i,
  input  logic             link_up_i,
  output logic [PHY_W-1:0] rdata_o
);
  logic [PHY_W-1:0] ctrl_q, adv_q, stat;
  logic             soft_rst;

  assign soft_rst = wr_i && (reg_i == PR_CTRL) && wdata_i[CTRL_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= '0;
    end else if (wr_i) begin
      if (reg_i == PR_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
      if (reg_i == PR_ADV)  adv_q  <= wdata_i;
    end
  end

  // link bit is live, so a soft reset cannot disturb it
  always_comb begin
    stat = STAT_BASE;
    stat[STAT_LINK_BIT] = link_up_i;
  end

  always_comb begin
    case (reg_i)
      PR_CTRL: rdata_o = ctrl_q;
      PR_STAT: rdata_o = stat;
      PR_IDHI: rdata_o = IDENT_HI;
      PR_IDLO: rdata_o = IDENT_LO;
      PR_ADV:  rdata_o = adv_q;
      PR_PART: rdata_o = PARTNER_ABIL;
      default: rdata_o = '0;
    endcase
  end

  assert_ctrl_soft_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ctrl_q == CTRL_DEFAULT) && (adv_q == '0));
  assert_ctrl_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == PR_CTRL && !wdata_i[CTRL_RST_BIT]) |=> !ctrl_q[15] && !ctrl_q[9]);
  assert_regs_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q) && $stable(adv_q));
endmodule

// File: rtl/mgmt_bus_regs.sv
module mgmt_bus_regs
  import mgmt_resp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] DATA_OFF = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              exec_rd_i,
  input  logic [PHY_W-1:0]  phy_rdata_i,
  output logic              cmd_stb_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic [DATA_W-1:0] cmd_q, data_q;
  logic              data_stb;

  assign cmd_stb_o = bus_en_i && bus_we_i && (bus_addr_i == CMD_OFF);
  assign data_stb  = bus_en_i && bus_we_i && (bus_addr_i == DATA_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_stb_o) begin
      cmd_q <= bus_wdata_i & ~(DATA_W'(1) << CMD_BUSY_BIT);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (exec_rd_i) begin
      data_q <= DATA_W'(phy_rdata_i);
    end else if (data_stb) begin
      data_q <= bus_wdata_i;
    end
  end

  always_comb begin
    if (bus_addr_i == CMD_OFF)       bus_rdata_o = cmd_q;
    else if (bus_addr_i == DATA_OFF) bus_rdata_o = data_q;
    else                             bus_rdata_o = '0;
  end

  assign data_o = data_q;

  assert_busy_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !bus_rdata_o[CMD_BUSY_BIT] || (bus_addr_i != CMD_OFF));
  assert_data_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_rd_i && !data_stb) |=> $stable(data_q));
endmodule

// File: rtl/mgmt_reg_responder.sv
module mgmt_reg_responder
  import mgmt_resp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PA_W-1:0]   cfg_phy_addr_i,
  input  logic              link_up_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic             cmd_stb, exec_rd, exec_wr;
  logic [RN_W-1:0]  reg_idx;
  logic [PHY_W-1:0] phy_rdata;
  logic [DATA_W-1:0] data_w;

  mgmt_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .exec_rd_i(exec_rd), .phy_rdata_i(phy_rdata),
    .cmd_stb_o(cmd_stb), .data_o(data_w), .bus_rdata_o
  );

  mgmt_cmd_decode u_dec (
    .cmd_stb_i(cmd_stb),
    .cmd_pa_i(bus_wdata_i[CMD_PA_LSB +: PA_W]),
    .cmd_rn_i(bus_wdata_i[CMD_RN_LSB +: RN_W]),
    .cmd_dir_i(bus_wdata_i[CMD_DIR_BIT]),
    .cfg_pa_i(cfg_phy_addr_i),
    .exec_rd_o(exec_rd), .exec_wr_o(exec_wr), .reg_idx_o(reg_idx)
  );

  mgmt_phy_regfile u_phy (
    .clk_i, .rst_ni, .wr_i(exec_wr), .reg_i(reg_idx),
    .wdata_i(data_w[PHY_W-1:0]), .link_up_i, .rdata_o(phy_rdata)
  );

  logic cmd_match;
  assign cmd_match = cmd_stb && (bus_wdata_i[15:12] == cfg_phy_addr_i);

  assert_id_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_match && !bus_wdata_i[1] && bus_wdata_i[7:4] == 4'd2) |=> data_w == DATA_W'(IDENT_HI));
  assert_mismatch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && !cmd_match) |=> $stable(data_w));
  assert_unknown_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_match && !bus_wdata_i[1] && bus_wdata_i[7:4] >= 4'd6) |=> data_w == '0);
endmodule

// File: tb/sim_mgmt_reg_responder.sv
module sim_mgmt_reg_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_pa = 4'h5;
  logic        link = 1'b1;
  logic        en = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  mgmt_reg_responder u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_phy_addr_i(cfg_pa), .link_up_i(link),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] cmd(logic [3:0] pa, logic [3:0] rn, logic w);
    return {16'h0, pa, 4'h0, rn, 2'b00, w, 1'b0};
  endfunction

  task automatic phy_rd(logic [3:0] rn, output logic [31:0] d);
    bus_wr(8'h00, cmd(cfg_pa, rn, 1'b0));
    bus_rd(8'h04, d);
  endtask

  task automatic phy_wr(logic [3:0] rn, logic [31:0] v);
    bus_wr(8'h04, v);
    bus_wr(8'h00, cmd(cfg_pa, rn, 1'b1));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(8'h00, d); check("R1 cmd", d, 0);
    bus_rd(8'h04, d); check("R1 data", d, 0);
    phy_rd(4'd0, d);  check("R1 reg0", d, 32'h3100);
    phy_rd(4'd4, d);  check("R1 reg4", d, 32'h0);
  endtask

  task automatic t_cmd_fields;
    logic [31:0] d;
    bus_wr(8'h00, 32'hA5A5_5011);
    bus_rd(8'h00, d); check("R2 busy cleared", d, 32'hA5A5_5010);
    bus_rd(8'h04, d); check("R7 status link up", d, 32'hFE2C);
    link = 0;
    phy_rd(4'd1, d);  check("R7 status link down", d, 32'hFE28);
    link = 1;
  endtask

  task automatic t_timing;
    logic [31:0] d;
    bus_wr(8'h04, 32'h0000_9999);
    bus_wr(8'h00, cmd(cfg_pa, 4'd3, 1'b0));
    bus_rd(8'h04, d); check("R3 next-cycle result", d, 32'h1400);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    phy_rd(4'd2, d); check("R8 id hi", d, 32'h0044);
    phy_wr(4'd2, 32'hFFFF); phy_wr(4'd3, 32'hFFFF);
    phy_rd(4'd2, d); check("R8 id hi after write", d, 32'h0044);
    phy_rd(4'd3, d); check("R8 id lo after write", d, 32'h1400);
    phy_rd(4'd5, d); check("R10 partner", d, 32'h0DE0);
    phy_wr(4'd5, 32'h0);
    phy_rd(4'd5, d); check("R10 partner after write", d, 32'h0DE0);
  endtask

  task automatic t_adv;
    logic [31:0] d;
    phy_wr(4'd4, 32'h1234);
    phy_rd(4'd4, d); check("R9 adv", d, 32'h1234);
    phy_wr(4'd4, 32'hABCD_05E1);
    phy_rd(4'd4, d); check("R11 upper cleared", d, 32'h05E1);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    phy_wr(4'd0, 32'h7FFF);
    phy_rd(4'd0, d); check("R5 ctrl masked", d, 32'h7DFF);
    phy_wr(4'd0, 32'h8000);
    phy_rd(4'd0, d); check("R6 ctrl default", d, 32'h3100);
    phy_rd(4'd4, d); check("R6 adv cleared", d, 32'h0);
    phy_rd(4'd1, d); check("R7 link kept", d, 32'hFE2C);
  endtask

  task automatic t_unknown;
    logic [31:0] d;
    bus_wr(8'h04, 32'hDEAD_BEEF);
    bus_wr(8'h00, cmd(cfg_pa, 4'd9, 1'b0));
    bus_rd(8'h04, d); check("R11 unknown 9", d, 32'h0);
    bus_wr(8'h04, 32'h1);
    bus_wr(8'h00, cmd(cfg_pa, 4'd15, 1'b0));
    bus_rd(8'h04, d); check("R11 unknown 15", d, 32'h0);
  endtask

  task automatic t_mismatch;
    logic [31:0] d;
    bus_wr(8'h04, 32'h0000_1111);
    bus_wr(8'h00, cmd(4'h3, 4'd2, 1'b0));
    bus_rd(8'h04, d); check("R4 data unchanged", d, 32'h1111);
    bus_wr(8'h00, cmd(4'h3, 4'd4, 1'b1));
    phy_rd(4'd4, d); check("R4 adv unchanged", d, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    bus_wr(8'h04, 32'hCAFE_F00D);
    bus_rd(8'h04, d); check("R12 data", d, 32'hCAFE_F00D);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_cmd_fields();
    t_timing();
    t_ids();
    t_adv();
    t_ctrl();
    t_unknown();
    t_mismatch();
    t_data();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule